// File: doc/BRIEF.md
# Oscillator Range Control Register

This block is a byte-wide control and status register for the range of a frequency-locked-loop oscillator. Software writes a two-bit range code and a fine-tune bit over a simple single-cycle write port in the bus-clock domain. The block turns these into an FLL multiplication factor, which it presents in the oscillator clock domain.

A range code accepted on the bus side is sent to the oscillator domain through a toggle request/acknowledge handshake. Every toggle line crosses through a two-flop synchronizer. The range-status field seen by software shows only the code that the oscillator domain has acknowledged, so it lags behind each write. The status is forced to zero when the clock-mode input selects a bypassed or PLL-driven mode. Range writes are blocked while the low-power or PLL-select qualifier is high.

Top module: `dco_range_reg`

## Requirements
- R1: After reset the range select is 00, the fine-tune bit is 0, `rdData` reads 0x00 and `fllFactor` is 512.
- R2: In clock modes 0 to 3, a write with range code 00 (low), 01 (mid) or 10 (high) in `wrData[1:0]` makes `rdData[1:0]` show that code once the handshake completes, within 30 bus cycles.
- R3: A write while `lowPower` or `pllSel` is 1 leaves the range select unchanged, and status and factor keep the old range. The fine-tune bit (`wrData[5]`) is still written.
- R4: A write of the reserved range code 11 is discarded and the previous range is kept.
- R5: `rdData` bits 7:6 and 4:2 always read 0 and write data in those bits has no effect. `rdData[5]` returns the fine-tune bit in the cycle after the write.
- R6: `rdData[1:0]` does not change in the cycle after a range write. It updates only after the round trip through the oscillator domain.
- R7: When `clkMode[2]` is 1 (modes 4 to 7: PLL engaged, PLL bypassed, low-power internal bypass, low-power external bypass), `rdData[1:0]` reads 00 whatever range is held.
- R8: With fine-tune 0, `fllFactor` is 512, 1024 or 1536 for range 00, 01 or 10.
- R9: With fine-tune 1, `fllFactor` is 608, 1216 or 1824 for range 00, 01 or 10.
- R10: `fllFactor` is registered in the oscillator domain. It changes only when a new code is accepted there, never in the bus cycle right after a write, and the code crossing the domains is held steady while a request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock |
| busRstN | input | 1 | Bus-side active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data: bit 5 fine-tune, bits 1:0 range |
| rdData | output | 8 | Read data: bit 5 fine-tune, bits 1:0 range status |
| clkMode | input | 3 | Current clock-mode code, 0 to 7 |
| lowPower | input | 1 | Low-power qualifier, blocks range writes |
| pllSel | input | 1 | PLL-select qualifier, blocks range writes |
| oscClk | input | 1 | Oscillator-domain clock |
| oscRstN | input | 1 | Oscillator-domain active-low reset |
| fllFactor | output | 11 | FLL multiplication factor, oscillator domain |

## Verification
The fine-tune readback and the reserved-bit zeros are due in the first bus cycle after the write edge. The clock-mode masking is combinational and is checked half a cycle after the mode changes. Range status and `fllFactor` need one bus cycle to launch the request, about three oscillator cycles to synchronize and accept it, and three bus cycles to bring the acknowledge back, which totals roughly twelve bus cycles. The bench therefore samples both results once at the falling edge right after the write, where they must still hold their old values. It samples them again after a fixed 30-cycle wait, where they must hold their new values.

// File: rtl/dco_rng_pkg.sv
package dco_rng_pkg;

  typedef enum logic [1:0] {
    RNG_LOW  = 2'b00,
    RNG_MID  = 2'b01,
    RNG_HIGH = 2'b10,
    RNG_RSVD = 2'b11
  } rngCode_e;

  // clock-mode codes; bit 2 set marks modes whose status reads zero
  typedef enum logic [2:0] {
    MODE_FLL_INT    = 3'd0,
    MODE_FLL_EXT    = 3'd1,
    MODE_FLLBYP_INT = 3'd2,
    MODE_FLLBYP_EXT = 3'd3,
    MODE_PLL_ENG    = 3'd4,
    MODE_PLL_BYP    = 3'd5,
    MODE_LP_INT     = 3'd6,
    MODE_LP_EXT     = 3'd7
  } clkMode_e;

  typedef struct packed {
    logic tuneLoad;
    logic rngLoad;
  } ctrlStrobe_t;

  typedef struct packed {
    logic       tune;
    logic [1:0] rng;
  } dcoCode_t;

endpackage

// File: rtl/dco_sync_bit.sv
module dco_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/dco_reg_ctrl.sv
module dco_reg_ctrl
  import dco_rng_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TUNE_BIT = 5
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lowPower,
  input  logic              pllSel,
  output ctrlStrobe_t       strb,
  output logic [1:0]        newRng,
  output logic              newTune
);
  logic rngBlocked;

  always_comb begin
    newRng        = wrData[1:0];
    newTune       = wrData[TUNE_BIT];
    rngBlocked    = lowPower || pllSel || (newRng == RNG_RSVD);
    strb.tuneLoad = wrEn;
    strb.rngLoad  = wrEn && !rngBlocked;
  end
endmodule

// File: rtl/dco_reg_bus.sv
module dco_reg_bus
  import dco_rng_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TUNE_BIT    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  ctrlStrobe_t       strb,
  input  logic [1:0]        newRng,
  input  logic              newTune,
  input  logic [2:0]        clkMode,
  input  logic              ackTgl,
  output logic              reqTgl,
  output dcoCode_t          sendCode,
  output logic [1:0]        curRng,
  output logic [DATA_W-1:0] rdData
);
  logic       tuneBit;
  logic       busy;
  logic       ackSync;
  logic [1:0] statusRng;
  dcoCode_t   heldCode;

  dco_sync_bit #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (busClk),
    .rstN(busRstN),
    .dIn (ackTgl),
    .dOut(ackSync)
  );

  assign heldCode = '{tune: tuneBit, rng: curRng};

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      curRng    <= RNG_LOW;
      tuneBit   <= 1'b0;
      reqTgl    <= 1'b0;
      busy      <= 1'b0;
      sendCode  <= '0;
      statusRng <= RNG_LOW;
    end else begin
      if (strb.rngLoad)  curRng  <= newRng;
      if (strb.tuneLoad) tuneBit <= newTune;
      if (busy) begin
        if (ackSync == reqTgl) begin
          busy      <= 1'b0;
          statusRng <= sendCode.rng;
        end
      end else if (heldCode != sendCode) begin
        sendCode <= heldCode;
        reqTgl   <= ~reqTgl;
        busy     <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[TUNE_BIT] = tuneBit;
    rdData[1:0]      = clkMode[2] ? 2'b00 : statusRng;
  end

  AST_NO_RSVD_CODE: assert property (@(posedge busClk) disable iff (!busRstN)
    curRng != RNG_RSVD); // R4
  AST_STATUS_LAG: assert property (@(posedge busClk) disable iff (!busRstN)
    (strb.rngLoad && !busy) |=> $stable(statusRng)); // R6
  AST_CODE_HELD: assert property (@(posedge busClk) disable iff (!busRstN)
    busy |=> $stable(sendCode)); // R10
endmodule

// File: rtl/dco_osc_side.sv
module dco_osc_side
  import dco_rng_pkg::*;
#(
  parameter int FACTOR_W    = 11,
  parameter int BASE_MULT   = 512,
  parameter int TUNED_MULT  = 608,
  parameter int SYNC_STAGES = 2
) (
  input  logic                oscClk,
  input  logic                oscRstN,
  input  logic                reqTgl,
  input  dcoCode_t            sendCode,
  output logic                ackTgl,
  output logic [FACTOR_W-1:0] fllFactor
);
  logic                reqSync;
  logic                accept;
  logic [FACTOR_W-1:0] nextFactor;
  int unsigned         mult;

  dco_sync_bit #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk (oscClk),
    .rstN(oscRstN),
    .dIn (reqTgl),
    .dOut(reqSync)
  );

  assign accept = (reqSync != ackTgl);

  always_comb begin
    mult       = sendCode.tune ? TUNED_MULT : BASE_MULT;
    nextFactor = FACTOR_W'((int'(sendCode.rng) + 1) * mult);
  end

  always_ff @(posedge oscClk or negedge oscRstN) begin
    if (!oscRstN) begin
      ackTgl    <= 1'b0;
      fllFactor <= FACTOR_W'(BASE_MULT);
    end else if (accept) begin
      ackTgl    <= reqSync;
      fllFactor <= nextFactor;
    end
  end

  AST_FACTOR_HOLD: assert property (@(posedge oscClk) disable iff (!oscRstN)
    !accept |=> $stable(fllFactor)); // R10
  AST_FACTOR_LEGAL: assert property (@(posedge oscClk) disable iff (!oscRstN)
    (fllFactor == FACTOR_W'(BASE_MULT))    || (fllFactor == FACTOR_W'(2*BASE_MULT)) ||
    (fllFactor == FACTOR_W'(3*BASE_MULT))  || (fllFactor == FACTOR_W'(TUNED_MULT)) ||
    (fllFactor == FACTOR_W'(2*TUNED_MULT)) || (fllFactor == FACTOR_W'(3*TUNED_MULT))); // R8 R9
endmodule

// File: rtl/dco_range_reg.sv
module dco_range_reg
  import dco_rng_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TUNE_BIT    = 5,
  parameter int FACTOR_W    = 11,
  parameter int BASE_MULT   = 512,
  parameter int TUNED_MULT  = 608,
  parameter int SYNC_STAGES = 2
) (
  input  logic                busClk,
  input  logic                busRstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [2:0]          clkMode,
  input  logic                lowPower,
  input  logic                pllSel,
  input  logic                oscClk,
  input  logic                oscRstN,
  output logic [FACTOR_W-1:0] fllFactor
);
  ctrlStrobe_t strb;
  logic [1:0]  newRng;
  logic        newTune;
  logic        reqTgl;
  logic        ackTgl;
  dcoCode_t    sendCode;
  logic [1:0]  curRng;

  dco_reg_ctrl #(.DATA_W(DATA_W), .TUNE_BIT(TUNE_BIT)) u_ctrl (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .lowPower(lowPower),
    .pllSel  (pllSel),
    .strb    (strb),
    .newRng  (newRng),
    .newTune (newTune)
  );

  dco_reg_bus #(.DATA_W(DATA_W), .TUNE_BIT(TUNE_BIT), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .busClk  (busClk),
    .busRstN (busRstN),
    .strb    (strb),
    .newRng  (newRng),
    .newTune (newTune),
    .clkMode (clkMode),
    .ackTgl  (ackTgl),
    .reqTgl  (reqTgl),
    .sendCode(sendCode),
    .curRng  (curRng),
    .rdData  (rdData)
  );

  dco_osc_side #(.FACTOR_W(FACTOR_W), .BASE_MULT(BASE_MULT), .TUNED_MULT(TUNED_MULT),
                 .SYNC_STAGES(SYNC_STAGES)) u_osc (
    .oscClk   (oscClk),
    .oscRstN  (oscRstN),
    .reqTgl   (reqTgl),
    .sendCode (sendCode),
    .ackTgl   (ackTgl),
    .fllFactor(fllFactor)
  );

  AST_GATED_WRITE: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && (lowPower || pllSel)) |=> $stable(curRng)); // R3
  AST_MODE_MASK: assert property (@(posedge busClk) disable iff (!busRstN)
    clkMode[2] |-> (rdData[1:0] == 2'b00)); // R7
endmodule

// File: tb/sim_dco_range_reg.sv
module sim_dco_range_reg;
  logic        busClk = 1'b0;
  logic        oscClk = 1'b0;
  logic        busRstN = 1'b0;
  logic        oscRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [2:0]  clkMode = 3'd0;
  logic        lowPower = 1'b0;
  logic        pllSel = 1'b0;
  logic [10:0] fllFactor;

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [1:0] expRng = 2'b00;
  logic       expTune = 1'b0;

  always #2 busClk = ~busClk;
  always #3.5 oscClk = ~oscClk;

  dco_range_reg u0 (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .clkMode(clkMode), .lowPower(lowPower), .pllSel(pllSel),
    .oscClk(oscClk), .oscRstN(oscRstN), .fllFactor(fllFactor)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int factorOf(input logic [1:0] r, input logic t);
    return (int'(r) + 1) * (t ? 608 : 512);
  endfunction

  task automatic waitBus(input int n);
    for (int i = 0; i < n; i++) @(negedge busClk);
  endtask

  // write at a falling edge, sample at the falling edge after the write edge
  task automatic busWrite(input logic [7:0] d, output logic [7:0] rdAfter, output logic [10:0] facAfter);
    @(negedge busClk);
    wrEn = 1'b1; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0; wrData = '0;
    rdAfter = rdData; facAfter = fllFactor;
  endtask

  task automatic tReset();
    chk("R1 rdData", int'(rdData), 0);
    chk("R1 factor", int'(fllFactor), 512);
  endtask

  task automatic tRanges();
    logic [7:0] r; logic [10:0] f;
    for (int t = 0; t < 2; t++) begin
      for (int g = 0; g < 3; g++) begin
        logic [1:0] oldRng; logic oldTune;
        oldRng = expRng; oldTune = expTune;
        busWrite({2'b00, t[0], 3'b000, g[1:0]}, r, f);
        chk("R6 status lags", int'(r[1:0]), int'(oldRng));
        chk("R10 factor held", int'(f), factorOf(oldRng, oldTune));
        chk("R5 tune readback", int'(r[5]), t);
        expRng = g[1:0]; expTune = t[0];
        waitBus(30);
        chk("R2 status", int'(rdData[1:0]), g);
        chk(t == 0 ? "R8 factor" : "R9 factor", int'(fllFactor), factorOf(expRng, expTune));
      end
    end
  endtask

  task automatic tGate();
    logic [7:0] r; logic [10:0] f;
    lowPower = 1'b1;
    busWrite(8'h01, r, f);            // range 01 blocked, tune 0 taken
    expTune = 1'b0;
    waitBus(30);
    chk("R3 lowPower status", int'(rdData[1:0]), int'(expRng));
    chk("R3 lowPower factor", int'(fllFactor), factorOf(expRng, expTune));
    lowPower = 1'b0; pllSel = 1'b1;
    busWrite(8'h20, r, f);            // range 00 blocked, tune 1 taken
    expTune = 1'b1;
    chk("R3 tune still written", int'(r[5]), 1);
    waitBus(30);
    chk("R3 pllSel status", int'(rdData[1:0]), int'(expRng));
    chk("R3 pllSel factor", int'(fllFactor), factorOf(expRng, expTune));
    pllSel = 1'b0;
  endtask

  task automatic tReservedCode();
    logic [7:0] r; logic [10:0] f;
    busWrite({2'b00, expTune, 3'b000, 2'b11}, r, f);
    waitBus(30);
    chk("R4 status kept", int'(rdData[1:0]), int'(expRng));
    chk("R4 factor kept", int'(fllFactor), factorOf(expRng, expTune));
  endtask

  task automatic tReservedBits();
    logic [7:0] r; logic [10:0] f;
    busWrite(8'hDC, r, f);            // reserved bits set, tune 0, range 00
    chk("R5 reserved zero now", int'(r & 8'hDC), 0);
    expRng = 2'b00; expTune = 1'b0;
    waitBus(30);
    chk("R5 read", int'(rdData), 0);
    busWrite(8'hDE, r, f);            // range 10, tune 0
    expRng = 2'b10;
    waitBus(30);
    chk("R5 read after", int'(rdData), 2);
    chk("R5 factor", int'(fllFactor), 1536);
  endtask

  task automatic tModeMask();
    for (int m = 0; m < 8; m++) begin
      @(negedge busClk);
      clkMode = m[2:0];
      #1;
      chk(m >= 4 ? "R7 masked" : "R7 visible", int'(rdData[1:0]), m >= 4 ? 0 : int'(expRng));
    end
    clkMode = 3'd0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests + 1, nFails);
      $finish;
    end
  end

  initial begin
    waitBus(3);
    busRstN = 1'b1; oscRstN = 1'b1;
    waitBus(2);
    tReset();
    tRanges();
    tGate();
    tReservedCode();
    tReservedBits();
    tModeMask();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule